// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This block holds the control and status registers of a small processor core and serves the three register instructions the core issues. A read returns the current value. A write stores the operand and hands back the previous contents. An exchange changes only the bits selected by a mask operand and hands back the value from before the change. The pipeline drives one request per cycle with an operation code, a register number, a data operand, a mask operand and a flag saying whether the core runs at user level. One clock later the unit returns the read data and raises at most one of three one-cycle flags. The flags are a privilege fault, an illegal-write trap, and a request to refresh state held further down the pipeline.

The register set is fixed and small. There are five writable control registers: three of them request a refresh when written, two do not. There are four constant identification and configuration registers, which cannot be written. There is also a bank of sixteen scratch registers with no side effects. Every other register number reads as zero and ignores writes without any flag. All stored registers clear on reset.

Top module: `csr_access_unit`

## Requirements
- R1: A request with `priv_user` high raises `priv_fault` in the response, returns zero, raises no other flag and changes no register, whatever the operation.
- R2: A read (op 0) returns the current value of an implemented register and zero for any number that is not implemented.
- R3: A write or exchange to a number that is not implemented returns zero, raises no flag and changes no register.
- R4: A write or exchange to one of the constant registers (0x10 to 0x13) raises `ill_trap`, returns zero and leaves the register value unchanged.
- R5: A write (op 1) stores `req_wdata` and returns the previous contents of the register.
- R6: An exchange (op 2) stores (wdata AND mask) OR (old AND NOT mask) and returns the old value.
- R7: A successful write or exchange to register 0x00, 0x02 or 0x18 raises `refresh_req`, even when the mask is zero. Reads, and writes to 0x01, 0x06 or the scratch bank, do not raise it.
- R8: Numbers 0x30 to 0x3F address sixteen independent scratch registers.
- R9: Register 0x10 reads the CORE_ID parameter, 0x11 reads the scratch count (16), 0x12 reads the data width (32) and 0x13 reads zero.
- R10: After reset every writable register reads zero, and all outputs are low.
- R11: The response appears in the cycle after the request, with `resp_valid` high for exactly that cycle. Each flag is a single-cycle pulse that only appears with `resp_valid`. Op code 3 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 read |
| req_csr | input | 8 | Register number |
| req_wdata | input | 32 | Data operand |
| req_mask | input | 32 | Bit mask for exchange |
| priv_user | input | 1 | Core runs at user level |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 32 | Read data or old value |
| priv_fault | output | 1 | Privilege violation pulse |
| ill_trap | output | 1 | Write to constant register pulse |
| refresh_req | output | 1 | Pipeline refresh request pulse |

## Verification
A write or exchange does two things in the same clock cycle: it returns the old contents and it stores the new value. On registers with a refresh attribute it also raises the refresh flag in that cycle. The bench provokes this by issuing requests back to back, with no idle cycles, to the same register. A read or exchange that immediately follows a write must therefore see the value committed one edge earlier, and the old value returned by that write must still be the earlier one. A scoreboard model judges each response. It tracks every register number and predicts the returned value and all three flags in one entry, so a response that has the right data but the wrong flag, or the reverse, is a mismatch.

// File: rtl/csr_access_pkg.sv
`timescale 1ns/1ps
package csr_access_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_XCHG  = 2'd2,
    OP_ALTRD = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_GEN   = 2'd1,
    KIND_SAVE  = 2'd2,
    KIND_CONST = 2'd3
  } csr_kind_e;

  localparam int NUM_GEN = 5;
  localparam int GIDX_W  = $clog2(NUM_GEN);

  // register numbers
  localparam int A_CTL   = 'h00;  // refresh on write
  localparam int A_PREV  = 'h01;
  localparam int A_EXTEN = 'h02;  // refresh on write
  localparam int A_EPC   = 'h06;
  localparam int A_ASID  = 'h18;  // refresh on write
  localparam int A_ID    = 'h10;  // constant
  localparam int A_CFG1  = 'h11;  // constant
  localparam int A_CFG2  = 'h12;  // constant
  localparam int A_CFG3  = 'h13;  // constant
endpackage

// File: rtl/csr_decode.sv
`timescale 1ns/1ps
module csr_decode
  import csr_access_pkg::*;
#(
  parameter int AW        = 8,
  parameter int XLEN      = 32,
  parameter int NUM_SAVE  = 16,
  parameter int SAVE_BASE = 'h30,
  parameter int CORE_ID   = 'h5A,
  localparam int SW       = $clog2(NUM_SAVE)
) (
  input  logic [AW-1:0]     csr_num,
  output csr_kind_e         kind,
  output logic              ro,
  output logic              refresh,
  output logic [GIDX_W-1:0] gidx,
  output logic [SW-1:0]     sidx,
  output logic [XLEN-1:0]   cval
);
  logic [AW-1:0] save_off;

  always_comb begin
    kind     = KIND_NONE;
    ro       = 1'b0;
    refresh  = 1'b0;
    gidx     = '0;
    cval     = '0;
    save_off = csr_num - AW'(SAVE_BASE);
    sidx     = save_off[SW-1:0];
    case (int'(csr_num))
      A_CTL:   begin kind = KIND_GEN; gidx = GIDX_W'(0); refresh = 1'b1; end
      A_PREV:  begin kind = KIND_GEN; gidx = GIDX_W'(1); end
      A_EXTEN: begin kind = KIND_GEN; gidx = GIDX_W'(2); refresh = 1'b1; end
      A_EPC:   begin kind = KIND_GEN; gidx = GIDX_W'(3); end
      A_ASID:  begin kind = KIND_GEN; gidx = GIDX_W'(4); refresh = 1'b1; end
      A_ID:    begin kind = KIND_CONST; ro = 1'b1; cval = XLEN'(CORE_ID); end
      A_CFG1:  begin kind = KIND_CONST; ro = 1'b1; cval = XLEN'(NUM_SAVE); end
      A_CFG2:  begin kind = KIND_CONST; ro = 1'b1; cval = XLEN'(XLEN); end
      A_CFG3:  begin kind = KIND_CONST; ro = 1'b1; end
      default: begin
        if (int'(csr_num) >= SAVE_BASE && int'(csr_num) < SAVE_BASE + NUM_SAVE)
          kind = KIND_SAVE;
      end
    endcase
  end
endmodule

// File: rtl/csr_bank.sv
`timescale 1ns/1ps
module csr_bank
  import csr_access_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_SAVE = 16,
  localparam int SW      = $clog2(NUM_SAVE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  csr_kind_e         kind,
  input  logic [GIDX_W-1:0] gidx,
  input  logic [SW-1:0]     sidx,
  input  logic [XLEN-1:0]   wval,
  output logic [XLEN-1:0]   rval
);
  logic [XLEN-1:0] gen_q  [NUM_GEN];
  logic [XLEN-1:0] save_q [NUM_SAVE];

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    always_ff @(posedge clk) begin
      if (rst) gen_q[g] <= '0;
      else if (we && kind == KIND_GEN && int'(gidx) == g) gen_q[g] <= wval;
    end
    p_gen_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !(we && kind == KIND_GEN && int'(gidx) == g) |=> $stable(gen_q[g]));
  end

  for (genvar s = 0; s < NUM_SAVE; s++) begin : g_save
    always_ff @(posedge clk) begin
      if (rst) save_q[s] <= '0;
      else if (we && kind == KIND_SAVE && int'(sidx) == s) save_q[s] <= wval;
    end
    p_save_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(we && kind == KIND_SAVE && int'(sidx) == s) |=> $stable(save_q[s]));
  end

  always_comb begin
    rval = '0;
    if (kind == KIND_GEN && int'(gidx) < NUM_GEN) rval = gen_q[gidx];
    else if (kind == KIND_SAVE) rval = save_q[sidx];
  end
endmodule

// File: rtl/csr_merge.sv
`timescale 1ns/1ps
module csr_merge
  import csr_access_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] new_val
);
  always_comb begin
    if (op == OP_XCHG) new_val = (src & mask) | (old_val & ~mask);
    else               new_val = src;
  end
endmodule

// File: rtl/csr_access_unit.sv
`timescale 1ns/1ps
module csr_access_unit
  import csr_access_pkg::*;
#(
  parameter int AW        = 8,
  parameter int XLEN      = 32,
  parameter int NUM_SAVE  = 16,
  parameter int SAVE_BASE = 'h30,
  parameter int CORE_ID   = 'h5A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_csr,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [XLEN-1:0] req_mask,
  input  logic            priv_user,
  output logic            resp_valid,
  output logic [XLEN-1:0] resp_rdata,
  output logic            priv_fault,
  output logic            ill_trap,
  output logic            refresh_req
);
  localparam int SW = $clog2(NUM_SAVE);

  csr_op_e           op;
  csr_kind_e         dec_kind;
  logic              dec_ro, dec_ref;
  logic [GIDX_W-1:0] dec_gidx;
  logic [SW-1:0]     dec_sidx;
  logic [XLEN-1:0]   dec_cval, bank_rval, cur_val, new_val, nxt_rdata;
  logic              legal, is_wr, impl, bad_wr, we;

  assign op = csr_op_e'(req_op);

  csr_decode #(.AW(AW), .XLEN(XLEN), .NUM_SAVE(NUM_SAVE),
               .SAVE_BASE(SAVE_BASE), .CORE_ID(CORE_ID)) u_dec (
    .csr_num(req_csr), .kind(dec_kind), .ro(dec_ro), .refresh(dec_ref),
    .gidx(dec_gidx), .sidx(dec_sidx), .cval(dec_cval));

  csr_bank #(.XLEN(XLEN), .NUM_SAVE(NUM_SAVE)) u_bank (
    .clk(clk), .rst(rst), .we(we), .kind(dec_kind), .gidx(dec_gidx),
    .sidx(dec_sidx), .wval(new_val), .rval(bank_rval));

  csr_merge #(.XLEN(XLEN)) u_merge (
    .op(op), .old_val(cur_val), .src(req_wdata), .mask(req_mask),
    .new_val(new_val));

  always_comb begin
    legal     = req_valid && !priv_user;
    is_wr     = (op == OP_WRITE) || (op == OP_XCHG);
    impl      = dec_kind != KIND_NONE;
    bad_wr    = legal && impl && is_wr && dec_ro;
    we        = legal && impl && is_wr && !dec_ro;
    cur_val   = (dec_kind == KIND_CONST) ? dec_cval : bank_rval;
    nxt_rdata = (legal && impl && !bad_wr) ? cur_val : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      priv_fault  <= 1'b0;
      ill_trap    <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_rdata  <= nxt_rdata;
      priv_fault  <= req_valid && priv_user;
      ill_trap    <= bad_wr;
      refresh_req <= we && dec_ref;
    end
  end

  p_user_fault_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && priv_user |=> priv_fault && !ill_trap && !refresh_req && resp_rdata == '0);

  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && dec_kind == KIND_NONE |=> resp_rdata == '0 && !ill_trap && !refresh_req);

  p_const_trap_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !priv_user && int'(req_csr) == A_ID &&
    (op == OP_WRITE || op == OP_XCHG) |=> ill_trap && resp_rdata == '0);

  p_one_flag_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({priv_fault, ill_trap, refresh_req}));

  p_flag_with_resp_r11: assert property (@(posedge clk) disable iff (rst)
    (priv_fault || ill_trap || refresh_req) |-> resp_valid);

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
endmodule

// File: tb/csr_access_unit_bench.sv
`timescale 1ns/1ps
module csr_access_unit_bench;
  localparam int CORE_ID = 'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [7:0]  req_csr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_mask = '0;
  logic        priv_user = 1'b0;
  logic        resp_valid, priv_fault, ill_trap, refresh_req;
  logic [31:0] resp_rdata;

  always #2.5 clk = ~clk;

  csr_access_unit #(.CORE_ID(CORE_ID)) u_csr_access_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_csr(req_csr), .req_wdata(req_wdata), .req_mask(req_mask),
    .priv_user(priv_user), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .priv_fault(priv_fault), .ill_trap(ill_trap), .refresh_req(refresh_req));

  typedef struct {
    logic [31:0] rd;
    logic        pf, tr, rf;
    int          rq;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] mdl [256];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic bit is_gen(int a);
    return a == 'h00 || a == 'h01 || a == 'h02 || a == 'h06 || a == 'h18;
  endfunction
  function automatic bit is_const(int a);
    return a >= 'h10 && a <= 'h13;
  endfunction
  function automatic bit is_save(int a);
    return a >= 'h30 && a <= 'h3F;
  endfunction
  function automatic bit is_ref(int a);
    return a == 'h00 || a == 'h02 || a == 'h18;
  endfunction

  task automatic issue(input logic [1:0] op, input int a, input logic [31:0] wd,
                       input logic [31:0] mk, input logic usr, input int rq);
    exp_t e;
    bit   wr, impl;
    e.rd = '0; e.pf = 0; e.tr = 0; e.rf = 0; e.rq = rq;
    wr   = (op == 2'd1) || (op == 2'd2);
    impl = is_gen(a) || is_const(a) || is_save(a);
    if (usr) e.pf = 1;
    else if (!impl) e.rd = '0;
    else if (wr && is_const(a)) e.tr = 1;
    else begin
      e.rd = mdl[a];
      if (op == 2'd1) mdl[a] = wd;
      else if (op == 2'd2) mdl[a] = (wd & mk) | (mdl[a] & ~mk);
      if (wr) e.rf = is_ref(a);
    end
    sbq.push_back(e);
    req_valid = 1'b1; req_op = op; req_csr = 8'(a);
    req_wdata = wd; req_mask = mk; priv_user = usr;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_op = '0; priv_user = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop and compare on every response
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (resp_valid) begin
        if (sbq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R11: unexpected response act=1 exp=0");
        end else begin
          exp_t e;
          e = sbq.pop_front();
          n_chk++;
          if (resp_rdata !== e.rd || priv_fault !== e.pf ||
              ill_trap !== e.tr || refresh_req !== e.rf) begin
            n_bad++;
            $display("FAIL R%0d: act rd=%h pf=%b tr=%b rf=%b exp rd=%h pf=%b tr=%b rf=%b",
                     e.rq, resp_rdata, priv_fault, ill_trap, refresh_req,
                     e.rd, e.pf, e.tr, e.rf);
          end
        end
      end else if (priv_fault || ill_trap || refresh_req) begin
        n_chk++; n_bad++;
        $display("FAIL R11: flag without response act=%b%b%b exp=000",
                 priv_fault, ill_trap, refresh_req);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R11: watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    mdl['h10] = CORE_ID; mdl['h11] = 32'd16; mdl['h12] = 32'd32; mdl['h13] = '0;
    repeat (4) @(negedge clk);
    // R10: outputs low under reset
    n_chk++;
    if (resp_valid || resp_rdata != 0 || priv_fault || ill_trap || refresh_req) begin
      n_bad++;
      $display("FAIL R10: reset outputs act=%b %h exp=0 0", resp_valid, resp_rdata);
    end
    rst = 1'b0;
    @(negedge clk);

    // R10/R9: reset contents and constants (R2 reads)
    foreach (mdl[a]) if (is_gen(a) || is_const(a) || is_save(a)) issue(2'd0, a, 0, 0, 0, 10);
    idle();

    // R5/R7: back-to-back writes on a refresh register
    issue(2'd1, 'h00, 32'hA5A5_0001, 0, 0, 5);
    issue(2'd1, 'h00, 32'h1234_5678, 0, 0, 7);
    issue(2'd0, 'h00, 0, 0, 0, 2);
    // R7: plain registers give no refresh
    issue(2'd1, 'h01, 32'hDEAD_BEEF, 0, 0, 7);
    issue(2'd1, 'h06, 32'hFFFF_0000, 0, 0, 7);
    // R6: exchange merge, then read back
    issue(2'd2, 'h06, 32'h1234_ABCD, 32'h0F0F_0F0F, 0, 6);
    issue(2'd0, 'h06, 0, 0, 0, 6);
    issue(2'd2, 'h18, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 7);
    issue(2'd2, 'h18, 32'h0, 32'h0, 0, 7);   // R7: zero mask still refreshes
    issue(2'd2, 'h02, 32'hCAFE_F00D, 32'hFFFF_FFFF, 0, 6);
    // R11: op 3 reads
    issue(2'd3, 'h02, 32'h5555_5555, 32'hFFFF_FFFF, 0, 11);
    idle();

    // R3: unimplemented numbers, including bank edges
    issue(2'd1, 'h07, 32'h1111_1111, 0, 0, 3);
    issue(2'd2, 'h2F, 32'h2222_2222, 32'hFFFF_FFFF, 0, 3);
    issue(2'd1, 'h40, 32'h3333_3333, 0, 0, 3);
    issue(2'd0, 'h07, 0, 0, 0, 2);
    issue(2'd0, 'hFF, 0, 0, 0, 2);
    issue(2'd0, 'h06, 0, 0, 0, 3);

    // R4: writes to constants trap and keep value
    issue(2'd1, 'h10, 32'hFFFF_FFFF, 0, 0, 4);
    issue(2'd2, 'h11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 4);
    issue(2'd1, 'h13, 32'h1, 0, 0, 4);
    issue(2'd0, 'h10, 0, 0, 0, 9);
    issue(2'd0, 'h11, 0, 0, 0, 9);

    // R1: user level faults, no state change
    issue(2'd1, 'h00, 32'h0BAD_0BAD, 0, 1, 1);
    issue(2'd2, 'h31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    issue(2'd0, 'h10, 0, 0, 1, 1);
    issue(2'd1, 'h10, 0, 0, 1, 1);
    issue(2'd0, 'h00, 0, 0, 0, 1);
    idle();

    // R8: fill and read back the scratch bank
    for (int s = 0; s < 16; s++) issue(2'd1, 'h30 + s, 32'h5A00_0000 + 32'(s * 'h0101), 0, 0, 8);
    for (int s = 0; s < 16; s++) issue(2'd0, 'h30 + s, 0, 0, 0, 8);
    idle();

    // mixed traffic over all classes (R1..R8)
    for (int k = 0; k < 600; k++) begin
      int a;
      case ($urandom % 10)
        0: a = 'h00; 1: a = 'h01; 2: a = 'h02; 3: a = 'h06; 4: a = 'h18;
        5: a = 'h10 + int'($urandom % 4);
        6: a = 'h07;
        default: a = 'h30 + int'($urandom % 16);
      endcase
      issue(2'($urandom % 4), a, $urandom, $urandom, ($urandom % 8) == 0, 6);
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11: pending act=%0d exp=0", sbq.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule